// File: doc/BRIEF.md
# Modulo-12 Up/Down Counter with Seven-Segment Scan

This block keeps a 4-bit count that runs over 0 to 11 and moves one step on each slow tick. A direction input picks up or down counting, a hold input freezes the value, and a synchronous counter reset returns it to zero. The three controls have a fixed order of precedence: reset wins over hold, and hold wins over stepping. The count leaves the wrapping range only if an illegal value is forced in. In that case the next up step goes to 0 and the next down step subtracts one.

The slow tick is a one-cycle enable pulse made by dividing the fast system clock. It is not a derived clock. The divider has its own reset. The divider reset also clears the display scanner.

The scanner drives an eight-digit multiplexed seven-segment display. It lights one digit at a time, with segments and anodes both active low. An enable vector decides which digits show the count as a hex glyph. Digits that are not enabled stay blank.

Top module: `mod12_updown_display`

## Requirements
- R1: While `cnt_rst_n` is low at a clock edge, `count` becomes 0 on that edge. This holds whatever `pause`, `up` and the tick are, and also when no tick occurs.
- R2: When `cnt_rst_n` is high and `pause` is high, `count` keeps its value through any number of ticks.
- R3: With reset and pause inactive and `up` high, each tick raises `count` by one.
- R4: With reset and pause inactive and `up` low, each tick lowers `count` by one.
- R5: An up step from 11 (4'b1011) gives 0.
- R6: A down step from 0 gives 11 (4'b1011).
- R7: `count` changes only on ticks. While `div_rst_n` is low, no tick occurs. After `div_rst_n` is sampled high at a clock edge, the first step of `count` happens TICK_DIV edges later, and each further step follows TICK_DIV edges after the one before.
- R8: A digit whose bit in `digit_en` is 0 never has its anode driven low. While no anode is low, `seg_n` is all ones.
- R9: At most one anode in `an_n` is low at a time. The scan visits digit indices 0,1,...,7 in rising order and wraps back to 0, spending SCAN_DIV cycles on each digit.
- R10: While an anode is low, `seg_n` shows the active-low glyph of `count`. Bit 0 is segment a and bit 6 is segment g. The active-high glyphs for 0 to F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71 (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| div_rst_n | input | 1 | Synchronous active-low reset of the tick divider and the digit scanner |
| cnt_rst_n | input | 1 | Synchronous active-low counter reset, highest precedence |
| pause | input | 1 | Holds the count while high |
| up | input | 1 | 1 selects counting up, 0 selects counting down |
| digit_en | input | NUM_DIGITS | Per-digit enable; a 0 blanks that digit |
| count | output | 4 | Current count, 0 to 11 |
| seg_n | output | 7 | Active-low segments, bit 0 = a through bit 6 = g |
| an_n | output | NUM_DIGITS | Active-low digit anodes, bit i = digit i |

## Verification
The bench controls the divider reset, so it knows the exact edge on which each tick lands. It uses this to make the counter reset coincide with a tick edge while the count is 3. The result must be 0, not 4.

Hold is also made to coincide with several ticks. Any change of `count` is then flagged by the monitor, because no expected value is queued.

Reset is also applied together with hold while the divider is held in reset. This shows that reset acts both over hold and without a tick.

// File: rtl/mod12_pkg.sv
// Package: shared widths, range limit and the hex-to-segment glyph function.
// Assumes segment bit 0 is segment a and bit 6 is segment g, active high here.
package mod12_pkg;
    localparam int CNT_W  = 4;
    localparam int SEG_W  = 7;
    localparam logic [CNT_W-1:0] CNT_TOP = 4'd11;

    typedef logic [CNT_W-1:0] count_t;
    typedef logic [SEG_W-1:0] seg_t;

    // Active-high segment pattern for one hex nibble.
    function automatic seg_t hex_glyph(input count_t v);
        seg_t g;
        case (v)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/tick_gen.sv
// Tick divider: emits a one-cycle enable pulse every DIV system clock cycles.
// Assumes DIV >= 2. The first pulse is visible DIV-1 edges after reset is
// sampled high, so the consumer acts on it at edge DIV.
module tick_gen #(
    parameter int unsigned DIV = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cyc_q;

    // Cycle counter with a registered terminal-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
            tick  <= 1'b0;
        end else if (cyc_q == LAST) begin
            cyc_q <= '0;
            tick  <= 1'b1;
        end else begin
            cyc_q <= cyc_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    // R7: a tick never lasts more than one cycle
    a_r7_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/mod12_core.sv
// Count core: a modulo-12 up/down register with precedence reset > pause > step.
// Assumes tick is a one-cycle enable in the same clock domain. An illegal value
// (12..15) goes to 0 on an up step and to value-1 on a down step.
module mod12_core
    import mod12_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   pause,
    input  logic   up,
    output count_t cnt_q
);
    count_t step_val;

    // Next value for one step in the selected direction, with wrap.
    always_comb begin
        if (up) begin
            step_val = (cnt_q >= CNT_TOP) ? '0 : cnt_q + 1'b1;
        end else begin
            step_val = (cnt_q == '0) ? CNT_TOP : cnt_q - 1'b1;
        end
    end

    // Count register: reset first, then hold, then step on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pause) begin
            cnt_q <= cnt_q;
        end else if (tick) begin
            cnt_q <= step_val;
        end
    end

    // R2: hold keeps the value
    a_r2_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pause |=> $stable(cnt_q));
    // R7: no change without a tick
    a_r7_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
    // R5: up wrap from the top
    a_r5_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pause && up && cnt_q == CNT_TOP) |=> cnt_q == '0);
    // R6: down wrap from zero
    a_r6_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pause && !up && cnt_q == '0) |=> cnt_q == CNT_TOP);
    // R5: the value stays inside 0..11 once reset has been seen
    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> cnt_q <= CNT_TOP);
endmodule

// File: rtl/seg_scan.sv
// Digit scanner: time-multiplexes one glyph across DIGITS active-low anodes.
// Assumes DIGITS >= 2 and SCAN_DIV >= 1. A disabled digit is blanked with all
// segments off. Outputs are registered, one cycle after the index and value.
module seg_scan
    import mod12_pkg::*;
#(
    parameter int unsigned SCAN_DIV = 100_000,
    parameter int unsigned DIGITS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  count_t            value,
    input  logic [DIGITS-1:0] dig_en,
    output seg_t              seg_n,
    output logic [DIGITS-1:0] an_n
);
    localparam int unsigned PW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam int unsigned IW = $clog2(DIGITS);
    localparam logic [PW-1:0] PRE_LAST = PW'(SCAN_DIV - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(DIGITS - 1);

    logic [PW-1:0]     pre_q;
    logic [IW-1:0]     idx_q;
    logic [DIGITS-1:0] an_d;
    seg_t              seg_d;

    // Dwell prescaler and digit index, advancing once per dwell period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            idx_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // One anode per digit, low only when selected and enabled.
    for (genvar g = 0; g < DIGITS; g++) begin : g_anode
        assign an_d[g] = !((idx_q == IW'(g)) && dig_en[g]);
    end

    // Segment pattern for the selected digit, blank when it is disabled.
    always_comb begin
        seg_d = dig_en[idx_q] ? ~hex_glyph(value) : '1;
    end

    // Output registers, cleared to all dark on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            an_n  <= '1;
            seg_n <= '1;
        end else begin
            an_n  <= an_d;
            seg_n <= seg_d;
        end
    end

    // R9: never more than one digit lit
    a_r9_one_anode: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~an_n) <= 1);
    // R8: no lit digit means dark segments
    a_r8_dark_when_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (an_n == '1) |-> (seg_n == '1));
endmodule

// File: rtl/mod12_updown_display.sv
// Top: tick divider, modulo-12 count core and seven-segment scanner.
// Assumes one system clock. div_rst_n clears the divider and the scanner;
// cnt_rst_n clears only the count. Both resets are synchronous and active low.
module mod12_updown_display
    import mod12_pkg::*;
#(
    parameter int unsigned TICK_DIV   = 100_000_000,
    parameter int unsigned SCAN_DIV   = 100_000,
    parameter int unsigned NUM_DIGITS = 8
) (
    input  logic                  clk,
    input  logic                  div_rst_n,
    input  logic                  cnt_rst_n,
    input  logic                  pause,
    input  logic                  up,
    input  logic [NUM_DIGITS-1:0] digit_en,
    output logic [CNT_W-1:0]      count,
    output logic [SEG_W-1:0]      seg_n,
    output logic [NUM_DIGITS-1:0] an_n
);
    logic   tick;
    count_t cnt_q;

    tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (div_rst_n),
        .tick  (tick)
    );

    mod12_core u_core (
        .clk   (clk),
        .rst_n (cnt_rst_n),
        .tick  (tick),
        .pause (pause),
        .up    (up),
        .cnt_q (cnt_q)
    );

    seg_scan #(.SCAN_DIV(SCAN_DIV), .DIGITS(NUM_DIGITS)) u_scan (
        .clk    (clk),
        .rst_n  (div_rst_n),
        .value  (cnt_q),
        .dig_en (digit_en),
        .seg_n  (seg_n),
        .an_n   (an_n)
    );

    assign count = cnt_q;

    // R1: reset forces zero on the next edge, whatever the tick does
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!div_rst_n)
        !cnt_rst_n |=> count == '0);
endmodule

// File: tb/test_mod12_updown_display.sv
module test_mod12_updown_display;
    localparam int TD = 20;
    localparam int SD = 4;

    logic       clk = 1'b0;
    logic       div_rst_n = 1'b0;
    logic       cnt_rst_n = 1'b0;
    logic       pause = 1'b0;
    logic       up = 1'b1;
    logic [7:0] digit_en = 8'h00;
    logic [3:0] count;
    logic [6:0] seg_n;
    logic [7:0] an_n;

    int checks = 0;
    int errs = 0;
    int model = 0;
    bit mon_en = 1'b0;
    logic [3:0] last_seen;
    logic [3:0] exp_q[$];

    always #2 clk = ~clk;

    mod12_updown_display #(.TICK_DIV(TD), .SCAN_DIV(SD), .NUM_DIGITS(8)) i_mod12_updown_display (
        .clk(clk), .div_rst_n(div_rst_n), .cnt_rst_n(cnt_rst_n), .pause(pause),
        .up(up), .digit_en(digit_en), .count(count), .seg_n(seg_n), .an_n(an_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R10 glyph table, active high
    function automatic logic [6:0] glyph(input int v);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[v];
    endfunction

    // R3..R6 expected next step
    function automatic int nxt(input int m, input bit u);
        if (u) return (m == 11) ? 0 : m + 1;
        return (m == 0) ? 11 : m - 1;
    endfunction

    // Monitor: every change of count is matched against the queue in order.
    always @(negedge clk) begin
        if (mon_en && count !== last_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R7 unexpected change", int'(count), int'(last_seen));
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                check(count === e, "R1-R6 scoreboard value", int'(count), int'(e));
            end
            last_seen = count;
        end
    end

    // Driver: aligns ticks by pulsing the divider reset, queues expected steps.
    task automatic phase(input bit up_v, input bit pause_v, input int n);
        int prev;
        @(negedge clk);
        div_rst_n = 1'b0; up = up_v; pause = pause_v;
        @(negedge clk);
        div_rst_n = 1'b1;
        for (int k = 0; k < n; k++) begin
            prev = model;
            if (!pause_v) begin
                model = nxt(model, up_v);
                exp_q.push_back(4'(model));
            end
            if (k == 0) begin
                repeat (TD) @(negedge clk);
                check(count == 4'(prev), "R7 no step before first tick", int'(count), prev);
                @(negedge clk);
            end else begin
                repeat (TD) @(negedge clk);
            end
        end
        div_rst_n = 1'b0;
        check(count == 4'(model), "R7 step lands on tick", int'(count), model);
        @(negedge clk);
        check(exp_q.size() == 0, "R7 all steps seen", exp_q.size(), 0);
    endtask

    // Display sampling: enable pattern, lit digits, glyph, scan order.
    task automatic disp(input logic [7:0] en, input int val);
        logic [7:0] seen;
        int blank_bad, glyph_bad, multi, order_bad, prev_i, run, idx, zeros;
        bit first_done;
        seen = '0; blank_bad = 0; glyph_bad = 0; multi = 0; order_bad = 0;
        prev_i = -1; run = 0; first_done = 1'b0;
        @(negedge clk);
        digit_en = en;
        repeat (3) @(negedge clk);
        for (int c = 0; c < 8 * SD * 3; c++) begin
            @(negedge clk);
            zeros = 0; idx = -1;
            for (int b = 0; b < 8; b++) if (!an_n[b]) begin zeros++; idx = b; end
            if (zeros > 1) multi++;
            if (zeros == 0) begin
                if (seg_n != 7'h7F) blank_bad++;
            end else begin
                seen[idx] = 1'b1;
                if (seg_n != ~glyph(val)) glyph_bad++;
                if (en == 8'hFF) begin
                    if (prev_i >= 0 && idx != prev_i) begin
                        if (idx != (prev_i + 1) % 8) order_bad++;
                        if (first_done && run != SD) order_bad++;
                        first_done = 1'b1;
                        run = 0;
                    end
                    prev_i = idx;
                    run++;
                end
            end
        end
        check(seen == en, "R8 lit digits match enable", int'(seen), int'(en));
        check(blank_bad == 0, "R8 dark segments when blank", blank_bad, 0);
        check(multi == 0, "R9 single anode", multi, 0);
        check(glyph_bad == 0, "R10 glyph", glyph_bad, 0);
        if (en == 8'hFF) check(order_bad == 0, "R9 order and dwell", order_bad, 0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(count == 4'd0, "R1 reset state", int'(count), 0);
        check(an_n == 8'hFF && seg_n == 7'h7F, "R8 dark after reset", int'(an_n), 255);
        cnt_rst_n = 1'b1;
        last_seen = count;
        mon_en = 1'b1;

        phase(1'b1, 1'b0, 5);       // R3: 1..5
        phase(1'b1, 1'b0, 8);       // R5: 6..11, 0, 1
        phase(1'b0, 1'b0, 3);       // R6 and R4: 0, 11, 10
        phase(1'b0, 1'b0, 4);       // R4: 9..6
        phase(1'b1, 1'b1, 3);       // R2: hold through ticks
        check(count == 4'd6, "R2 pause holds", int'(count), 6);

        // R1 reset over pause with no tick present
        @(negedge clk);
        pause = 1'b1; cnt_rst_n = 1'b0;
        model = 0; exp_q.push_back(4'd0);
        @(negedge clk);
        check(count == 4'd0, "R1 reset over pause", int'(count), 0);
        cnt_rst_n = 1'b1;

        phase(1'b0, 1'b0, 1);       // R6: 11
        phase(1'b1, 1'b0, 4);       // R5: 0..3

        // R1 reset on the same edge as a tick, count 3 would otherwise give 4
        @(negedge clk);
        div_rst_n = 1'b0; up = 1'b1; pause = 1'b0;
        @(negedge clk);
        div_rst_n = 1'b1;
        repeat (TD) @(negedge clk);
        cnt_rst_n = 1'b0;
        model = 0; exp_q.push_back(4'd0);
        @(negedge clk);
        check(count == 4'd0, "R1 reset wins over tick", int'(count), 0);
        cnt_rst_n = 1'b1; div_rst_n = 1'b0;
        @(negedge clk);

        phase(1'b0, 1'b0, 2);       // R4: 11, 10

        // Display at count 10 with the divider running and the count held
        @(negedge clk);
        pause = 1'b1; div_rst_n = 1'b1;
        disp(8'h00, 10);
        disp(8'hFF, 10);
        disp(8'h24, 10);

        phase(1'b1, 1'b0, 1);       // R3: 11
        @(negedge clk);
        pause = 1'b1; div_rst_n = 1'b1;
        disp(8'hFF, 11);
        disp(8'h81, 11);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2 nothing pending at end", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule